// File: doc/BRIEF.md
# Circular Descriptor Ring Fetcher

The block walks a circular queue of four-dword transfer descriptors that software keeps in host memory. Software supplies a 64-bit ring base, a mask that sets the ring size, a re-read interval in milliseconds, an enable and a clear. The block reads each descriptor one dword at a time over a simple memory-request port. It then inspects the ownership flag of the descriptor and acts on it.

An owned descriptor goes to a downstream executor over a valid/ready port. When the executor reports completion, the block writes the first dword back to host memory with the ownership flag cleared. It then moves to the next slot and wraps at the end of the ring. A descriptor that is not yet owned leaves the pointer where it is, and the block reads it again once a millisecond timer expires or when software strobes a poll-now input.

A descriptor of the register-setting kind carries no data. Instead it loads one of two upper board-address registers, one for each direction. For debug, the block also shows the address it is reading and the address of the descriptor it is working on.

Top module: `desc_ring_fetch`

## Requirements
- R1: After reset no memory request and no descriptor offer are active, the re-read interval reads 1, and curReadAddr equals cfgBaseLo.
- R2: A write of 0 to the re-read interval stores 1. A write of any other value stores that value, visible on rereadVal on the cycle after the write.
- R3: A descriptor is fetched as four single-dword reads at byte offsets 0, 4, 8 and 12 from the slot address. Each read is issued only after the previous response has arrived. memReqAddr[63:32] always equals cfgBaseHi.
- R4: An owned descriptor is offered with descCtl = dword0, descBoardAddr = dword1, descHostAddr = {dword3, dword2 with bits 1:0 forced to 0}. The offer and its fields hold until descReady. Ownership is dword0 bit 31 = 1.
- R5: After execDone, a single write goes to the slot address with data dword0 and bit 31 cleared. irqPulse is high in that write cycle exactly when dword0 bit 29 = 1 and bit 28 = 0.
- R6: The slot offset advances as (offset + 16) AND ringMask, and the address is cfgBaseLo OR offset. ringMask reads {zeros, cfgMaskBits at bits 19:12, ones at bits 11:0}, so the last slot is followed by the base.
- R7: A fetched descriptor with bit 31 = 0 keeps the pointer in place. The next read of its dword0 starts 9 + rereadVal*TICKS_PER_MS cycles after the previous one.
- R8: A poll-now pulse while waiting starts the re-read of the same slot on the next cycle, without waiting for the timer.
- R9: While cfgClear is high, no request or offer is active, the pointer is back at the base, and pending work is dropped. After release, fetching restarts at the base.
- R10: With cfgEnable low, no fetch is started.
- R11: A descriptor with bit 28 = 1 is not offered. It loads dword1 into boardHiToHost when bit 30 = 1, or into boardHiFromHost when bit 30 = 0. It is written back without an interrupt.
- R12: curExecAddr shows the low 32 bits of the slot address of the descriptor being executed or written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBaseLo | input | 32 | Ring base, low half |
| cfgBaseHi | input | 32 | Ring base, high half |
| cfgMaskBits | input | MASK_BITS | Writable ring mask bits (19:12) |
| ringMask | output | 32 | Effective ring mask |
| rereadWr | input | 1 | Write strobe for the re-read interval |
| rereadData | input | MS_BITS | Interval to write, in ms |
| rereadVal | output | MS_BITS | Stored interval |
| cfgEnable | input | 1 | Fetch enable |
| cfgClear | input | 1 | Hold-in-clear control |
| pollNow | input | 1 | Re-read immediately |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory request accepted |
| memReqWrite | output | 1 | Request is a write |
| memReqAddr | output | 64 | Request byte address |
| memReqWdata | output | 32 | Write data |
| memRspValid | input | 1 | Read response valid |
| memRspData | input | 32 | Read response dword |
| descValid | output | 1 | Descriptor offered |
| descReady | input | 1 | Executor takes descriptor |
| descCtl | output | 32 | Control dword |
| descBoardAddr | output | 32 | Board dword address |
| descHostAddr | output | 64 | Host byte address |
| execDone | input | 1 | Executor finished the descriptor |
| irqPulse | output | 1 | Completion interrupt request |
| boardHiToHost | output | 32 | Upper board address, to-host |
| boardHiFromHost | output | 32 | Upper board address, from-host |
| curReadAddr | output | 32 | Address being read (debug) |
| curExecAddr | output | 32 | Descriptor in execution (debug) |

## Verification
Each dword read costs two cycles: the response arrives on the cycle after acceptance and is captured at the next edge. The check state then adds one cycle, and the wait state lasts rereadVal*TICKS_PER_MS cycles. The bench therefore counts falling edges between successive dword0 reads and expects 9 + N. A poll strobe driven in the first wait cycle must show the re-read on the very next cycle. Register-visible results (interval readback, upper board registers, the pointer after clear) are sampled one edge after the causing event, and write-back data and irqPulse are compared in the same cycle the write request is visible.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int VALID_BIT  = 31;
  localparam int DIR_BIT    = 30;
  localparam int IRQ_BIT    = 29;
  localparam int SETREG_BIT = 28;
  localparam int DESC_BYTES = 16;
  localparam int DESC_WORDS = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_RDREQ, S_RDRSP, S_CHECK, S_WAIT, S_OFFER, S_EXEC, S_WB
  } fetchState_t;

  typedef struct packed {
    logic       ptrClear;
    logic       ptrAdvance;
    logic       capture;
    logic       latchExec;
    logic       timerLoad;
    logic       timerRun;
    logic       hiLoad;
    logic [1:0] wordIdx;
  } ctrlStrobes_t;
endpackage

// File: rtl/ring_ctrl.sv
module ring_ctrl
  import ring_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgEnable,
  input  logic         cfgClear,
  input  logic         pollNow,
  input  logic         memReqReady,
  input  logic         memRspValid,
  input  logic         descReady,
  input  logic         execDone,
  input  logic         timerZero,
  input  logic         w0Valid,
  input  logic         w0SetReg,
  input  logic         w0Irq,
  output ctrlStrobes_t st,
  output logic         memReqValid,
  output logic         memReqWrite,
  output logic         descValid,
  output logic         irqPulse
);
  fetchState_t state, stateNext;
  logic [1:0]  wordIdx, wordIdxNext;

  always_ff @(posedge clk) begin
    if (!rstN || cfgClear) begin
      state   <= S_IDLE;
      wordIdx <= '0;
    end else begin
      state   <= stateNext;
      wordIdx <= wordIdxNext;
    end
  end

  always_comb begin
    stateNext   = state;
    wordIdxNext = wordIdx;
    st          = '0;
    st.wordIdx  = wordIdx;
    st.ptrClear = cfgClear;
    if (!cfgClear) begin
      case (state)
        S_IDLE: if (cfgEnable) begin
          stateNext   = S_RDREQ;
          wordIdxNext = '0;
        end
        S_RDREQ: if (memReqReady) stateNext = S_RDRSP;
        S_RDRSP: if (memRspValid) begin
          st.capture = 1'b1;
          if (wordIdx == 2'(DESC_WORDS - 1)) begin
            stateNext = S_CHECK;
          end else begin
            wordIdxNext = wordIdx + 2'd1;
            stateNext   = S_RDREQ;
          end
        end
        S_CHECK: begin
          wordIdxNext = '0;
          if (!w0Valid) begin
            st.timerLoad = 1'b1;
            stateNext    = S_WAIT;
          end else if (w0SetReg) begin
            st.hiLoad    = 1'b1;
            st.latchExec = 1'b1;
            stateNext    = S_WB;
          end else begin
            st.latchExec = 1'b1;
            stateNext    = S_OFFER;
          end
        end
        S_WAIT: begin
          if (!cfgEnable)                stateNext = S_IDLE;
          else if (pollNow || timerZero) stateNext = S_RDREQ;
          else                           st.timerRun = 1'b1;
        end
        S_OFFER: if (descReady) stateNext = S_EXEC;
        S_EXEC:  if (execDone)  stateNext = S_WB;
        S_WB: if (memReqReady) begin
          st.ptrAdvance = 1'b1;
          stateNext     = cfgEnable ? S_RDREQ : S_IDLE;
        end
        default: stateNext = S_IDLE;
      endcase
    end
  end

  assign memReqValid = !cfgClear && (state == S_RDREQ || state == S_WB);
  assign memReqWrite = (state == S_WB);
  assign descValid   = !cfgClear && (state == S_OFFER);
  assign irqPulse    = !cfgClear && (state == S_WB) && memReqReady && w0Irq && !w0SetReg;
endmodule

// File: rtl/ring_dpath.sv
module ring_dpath
  import ring_pkg::*;
#(
  parameter int TICKS_PER_MS = 125000,
  parameter int MASK_BITS    = 8,
  parameter int MS_BITS      = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         st,
  input  logic                 memReqWrite,
  input  logic [31:0]          cfgBaseLo,
  input  logic [31:0]          cfgBaseHi,
  input  logic [MASK_BITS-1:0] cfgMaskBits,
  input  logic                 rereadWr,
  input  logic [MS_BITS-1:0]   rereadData,
  input  logic [31:0]          memRspData,
  output logic [31:0]          ringMask,
  output logic [MS_BITS-1:0]   rereadVal,
  output logic [63:0]          memReqAddr,
  output logic [31:0]          memReqWdata,
  output logic [31:0]          descCtl,
  output logic [31:0]          descBoardAddr,
  output logic [63:0]          descHostAddr,
  output logic [31:0]          boardHiToHost,
  output logic [31:0]          boardHiFromHost,
  output logic [31:0]          curReadAddr,
  output logic [31:0]          curExecAddr,
  output logic                 timerZero,
  output logic                 w0Valid,
  output logic                 w0SetReg,
  output logic                 w0Irq
);
  localparam int MASK_LSB  = 12;
  localparam int MASK_HI   = MASK_LSB + MASK_BITS;
  localparam int MAX_TICKS = TICKS_PER_MS * ((1 << MS_BITS) - 1);
  localparam int TIMER_W   = $clog2(MAX_TICKS + 1);

  logic [31:0]        ptrOff, descAddr, execQ;
  logic [MS_BITS-1:0] rereadQ;
  logic [TIMER_W-1:0] timerCnt;
  logic [31:0]        hiTo, hiFrom;
  logic [31:0]        words [DESC_WORDS];

  assign ringMask = {{(32 - MASK_HI){1'b0}}, cfgMaskBits, {MASK_LSB{1'b1}}};
  assign descAddr = cfgBaseLo | ptrOff;

  for (genvar i = 0; i < DESC_WORDS; i++) begin : g_word
    logic [31:0] wordQ;
    always_ff @(posedge clk) begin
      if (!rstN)                                  wordQ <= '0;
      else if (st.capture && st.wordIdx == 2'(i)) wordQ <= memRspData;
    end
    assign words[i] = wordQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              ptrOff <= '0;
    else if (st.ptrClear)   ptrOff <= '0;
    else if (st.ptrAdvance) ptrOff <= (ptrOff + 32'(DESC_BYTES)) & ringMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         rereadQ <= MS_BITS'(1);
    else if (rereadWr) rereadQ <= (rereadData == '0) ? MS_BITS'(1) : rereadData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             execQ <= '0;
    else if (st.latchExec) execQ <= descAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             timerCnt <= '0;
    else if (st.timerLoad) timerCnt <= TIMER_W'(rereadQ) * TIMER_W'(TICKS_PER_MS) - TIMER_W'(1);
    else if (st.timerRun)  timerCnt <= timerCnt - TIMER_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiTo   <= '0;
      hiFrom <= '0;
    end else if (st.hiLoad) begin
      if (words[0][DIR_BIT]) hiTo   <= words[1];
      else                   hiFrom <= words[1];
    end
  end

  assign timerZero       = (timerCnt == '0);
  assign rereadVal       = rereadQ;
  assign curReadAddr     = descAddr + {28'd0, st.wordIdx, 2'b00};
  assign curExecAddr     = execQ;
  assign memReqAddr      = {cfgBaseHi, memReqWrite ? execQ : curReadAddr};
  assign memReqWdata     = words[0] & ~(32'd1 << VALID_BIT);
  assign descCtl         = words[0];
  assign descBoardAddr   = words[1];
  assign descHostAddr    = {words[3], words[2][31:2], 2'b00};
  assign boardHiToHost   = hiTo;
  assign boardHiFromHost = hiFrom;
  assign w0Valid         = words[0][VALID_BIT];
  assign w0SetReg        = words[0][SETREG_BIT];
  assign w0Irq           = words[0][IRQ_BIT];
endmodule

// File: rtl/desc_ring_fetch.sv
module desc_ring_fetch
  import ring_pkg::*;
#(
  parameter int TICKS_PER_MS = 125000,
  parameter int MASK_BITS    = 8,
  parameter int MS_BITS      = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [31:0]          cfgBaseLo,
  input  logic [31:0]          cfgBaseHi,
  input  logic [MASK_BITS-1:0] cfgMaskBits,
  output logic [31:0]          ringMask,
  input  logic                 rereadWr,
  input  logic [MS_BITS-1:0]   rereadData,
  output logic [MS_BITS-1:0]   rereadVal,
  input  logic                 cfgEnable,
  input  logic                 cfgClear,
  input  logic                 pollNow,
  output logic                 memReqValid,
  input  logic                 memReqReady,
  output logic                 memReqWrite,
  output logic [63:0]          memReqAddr,
  output logic [31:0]          memReqWdata,
  input  logic                 memRspValid,
  input  logic [31:0]          memRspData,
  output logic                 descValid,
  input  logic                 descReady,
  output logic [31:0]          descCtl,
  output logic [31:0]          descBoardAddr,
  output logic [63:0]          descHostAddr,
  input  logic                 execDone,
  output logic                 irqPulse,
  output logic [31:0]          boardHiToHost,
  output logic [31:0]          boardHiFromHost,
  output logic [31:0]          curReadAddr,
  output logic [31:0]          curExecAddr
);
  ctrlStrobes_t st;
  logic timerZero, w0Valid, w0SetReg, w0Irq;

  ring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgClear(cfgClear),
    .pollNow(pollNow), .memReqReady(memReqReady), .memRspValid(memRspValid),
    .descReady(descReady), .execDone(execDone), .timerZero(timerZero),
    .w0Valid(w0Valid), .w0SetReg(w0SetReg), .w0Irq(w0Irq), .st(st),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .descValid(descValid), .irqPulse(irqPulse)
  );

  ring_dpath #(
    .TICKS_PER_MS(TICKS_PER_MS), .MASK_BITS(MASK_BITS), .MS_BITS(MS_BITS)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .memReqWrite(memReqWrite),
    .cfgBaseLo(cfgBaseLo), .cfgBaseHi(cfgBaseHi), .cfgMaskBits(cfgMaskBits),
    .rereadWr(rereadWr), .rereadData(rereadData), .memRspData(memRspData),
    .ringMask(ringMask), .rereadVal(rereadVal), .memReqAddr(memReqAddr),
    .memReqWdata(memReqWdata), .descCtl(descCtl), .descBoardAddr(descBoardAddr),
    .descHostAddr(descHostAddr), .boardHiToHost(boardHiToHost),
    .boardHiFromHost(boardHiFromHost), .curReadAddr(curReadAddr),
    .curExecAddr(curExecAddr), .timerZero(timerZero), .w0Valid(w0Valid),
    .w0SetReg(w0SetReg), .w0Irq(w0Irq)
  );
endmodule

// File: rtl/desc_ring_fetch_chk.sv
module desc_ring_fetch_chk #(
  parameter int MS_BITS = 10
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgClear,
  input logic               memReqValid,
  input logic               memReqReady,
  input logic               memReqWrite,
  input logic [63:0]        memReqAddr,
  input logic [31:0]        memReqWdata,
  input logic               descValid,
  input logic               descReady,
  input logic [31:0]        descCtl,
  input logic               irqPulse,
  input logic [MS_BITS-1:0] rereadVal
);
  // R4
  offered_owned_chk: assert property (@(posedge clk) disable iff (!rstN)
    descValid |-> descCtl[31]);

  // R4
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rstN || cfgClear)
    descValid && !descReady |=> descValid && $stable(descCtl));

  // R5
  wb_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqWrite |-> !memReqWdata[31]);

  // R11
  irq_in_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> memReqValid && memReqWrite && memReqReady);

  // R9
  clear_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgClear |=> !memReqValid && !descValid);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN || cfgClear)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  // R2
  reread_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rereadVal != '0);
endmodule

bind desc_ring_fetch desc_ring_fetch_chk #(.MS_BITS(MS_BITS)) u_chk (.*);

// File: tb/desc_ring_fetch_tb.sv
`timescale 1ns/1ps
module desc_ring_fetch_tb;
  localparam int TICKS   = 5;
  localparam int REREAD  = 2;
  localparam int PERIOD  = 9 + REREAD * TICKS;
  localparam int RING    = 512;
  localparam logic [31:0] BASE_LO = 32'h0004_0000;
  localparam logic [31:0] BASE_HI = 32'h0000_0012;

  logic clk = 1'b0, rstN = 1'b0;
  logic [7:0]  cfgMaskBits = 8'h01;
  logic [31:0] ringMask;
  logic        rereadWr = 1'b0;
  logic [9:0]  rereadData = '0, rereadVal;
  logic        cfgEnable = 1'b0, cfgClear = 1'b0, pollNow = 1'b0;
  logic        memReqValid, memReqWrite, memReqReady = 1'b1;
  logic [63:0] memReqAddr;
  logic [31:0] memReqWdata;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        descValid, descReady = 1'b0, execDone = 1'b0, irqPulse;
  logic [31:0] descCtl, descBoardAddr, boardHiToHost, boardHiFromHost;
  logic [63:0] descHostAddr;
  logic [31:0] curReadAddr, curExecAddr;

  always #10 clk = ~clk;

  desc_ring_fetch #(.TICKS_PER_MS(TICKS), .MASK_BITS(8), .MS_BITS(10)) u_dut (
    .clk(clk), .rstN(rstN), .cfgBaseLo(BASE_LO), .cfgBaseHi(BASE_HI),
    .cfgMaskBits(cfgMaskBits), .ringMask(ringMask), .rereadWr(rereadWr),
    .rereadData(rereadData), .rereadVal(rereadVal), .cfgEnable(cfgEnable),
    .cfgClear(cfgClear), .pollNow(pollNow), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memReqWdata(memReqWdata), .memRspValid(memRspValid), .memRspData(memRspData),
    .descValid(descValid), .descReady(descReady), .descCtl(descCtl),
    .descBoardAddr(descBoardAddr), .descHostAddr(descHostAddr),
    .execDone(execDone), .irqPulse(irqPulse), .boardHiToHost(boardHiToHost),
    .boardHiFromHost(boardHiFromHost), .curReadAddr(curReadAddr),
    .curExecAddr(curExecAddr)
  );

  int  checks = 0, fails = 0;
  int  expIdx = 0, wbCount = 0;
  bit  validArr [RING];
  bit  finished = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit isSetReg(input int idx);
    return (idx % 7) == 3;
  endfunction

  // dword0: bit31 owner, bit30 to-host, bit29 interrupt, bit28 set-register, bits23:0 length
  function automatic logic [31:0] mkWord(input int idx, input int k, input bit v);
    logic [31:0] w;
    case (k)
      0: w = {v, idx[0], idx[1], isSetReg(idx), idx[2], 3'b000, 24'(idx * 3 + 1)};
      1: w = 32'hB000_0000 | 32'(idx);
      2: w = 32'h8000_0003 | (32'(idx) << 4);
      default: w = 32'h0000_00A0 + 32'(idx);
    endcase
    return w;
  endfunction

  function automatic logic [31:0] slotAddr(input int idx);
    return BASE_LO + 32'(idx * 16);
  endfunction

  // memory responder: one response the cycle after each accepted read
  initial begin
    bit          pend = 0;
    logic [31:0] pendData = '0;
    forever begin
      @(negedge clk);
      memRspValid = pend;
      memRspData  = pendData;
      pend = memReqValid && !memReqWrite && memReqReady;
      if (pend) begin
        automatic int idx = int'((memReqAddr[31:0] - BASE_LO) >> 4) % RING;
        automatic int k   = int'(memReqAddr[3:2]);
        pendData = mkWord(idx, k, (k == 0) ? validArr[idx] : 1'b1);
      end
    end
  end

  // request monitor: read addresses, write-back contents, interrupt, upper registers
  initial begin
    forever begin
      @(negedge clk);
      if (memReqValid && !memReqWrite) begin
        check(memReqAddr[63:32] == BASE_HI, "R3 read upper address", memReqAddr[63:32], BASE_HI);
        check(memReqAddr[31:4] == slotAddr(expIdx)[31:4], "R6 read slot address",
              memReqAddr[31:0], slotAddr(expIdx));
      end
      if (memReqValid && memReqWrite) begin
        automatic logic [31:0] w0 = mkWord(expIdx, 0, 1'b1);
        check(memReqAddr == {BASE_HI, slotAddr(expIdx)}, "R5 write-back address",
              memReqAddr, {BASE_HI, slotAddr(expIdx)});
        check(memReqWdata == (w0 & 32'h7FFF_FFFF), "R5 write-back data",
              memReqWdata, w0 & 32'h7FFF_FFFF);
        check(curExecAddr == slotAddr(expIdx), "R12 exec address", curExecAddr, slotAddr(expIdx));
        if (isSetReg(expIdx)) begin
          check(irqPulse == 1'b0, "R11 no interrupt for set-register", irqPulse, 0);
          if (w0[30]) check(boardHiToHost == mkWord(expIdx, 1, 1'b1), "R11 to-host upper",
                            boardHiToHost, mkWord(expIdx, 1, 1'b1));
          else        check(boardHiFromHost == mkWord(expIdx, 1, 1'b1), "R11 from-host upper",
                            boardHiFromHost, mkWord(expIdx, 1, 1'b1));
        end else begin
          check(irqPulse == w0[29], "R5 interrupt pulse", irqPulse, w0[29]);
        end
        validArr[expIdx] = 1'b0;
        expIdx = (expIdx + 1) % RING;
        wbCount++;
      end
    end
  end

  // executor model
  initial begin
    forever begin
      @(negedge clk);
      if (descValid) begin
        check(!isSetReg(expIdx), "R11 set-register not offered", 64'(expIdx), 0);
        check(descCtl == mkWord(expIdx, 0, 1'b1), "R4 control dword", descCtl, mkWord(expIdx, 0, 1'b1));
        check(descBoardAddr == mkWord(expIdx, 1, 1'b1), "R4 board address",
              descBoardAddr, mkWord(expIdx, 1, 1'b1));
        check(descHostAddr == {mkWord(expIdx, 3, 1'b1), mkWord(expIdx, 2, 1'b1) & 32'hFFFF_FFFC},
              "R4 host address", descHostAddr,
              {mkWord(expIdx, 3, 1'b1), mkWord(expIdx, 2, 1'b1) & 32'hFFFF_FFFC});
        descReady = 1'b1;
        @(negedge clk);
        descReady = 1'b0;
        repeat (2) @(negedge clk);
        execDone = 1'b1;
        @(negedge clk);
        execDone = 1'b0;
      end
    end
  end

  task automatic writeReread(input logic [9:0] v, input logic [9:0] expect_v);
    @(negedge clk);
    rereadWr = 1'b1;
    rereadData = v;
    @(negedge clk);
    rereadWr = 1'b0;
    check(rereadVal == expect_v, "R2 re-read interval write", rereadVal, expect_v);
  endtask

  task automatic waitRead(input logic [31:0] addr);
    do @(negedge clk); while (!(memReqValid && !memReqWrite && memReqAddr[31:0] == addr));
  endtask

  initial begin
    int target;
    int gap;
    bit seen;
    for (int i = 0; i < RING; i++) validArr[i] = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(memReqValid == 1'b0, "R1 no request", memReqValid, 0);
    check(descValid == 1'b0, "R1 no offer", descValid, 0);
    check(rereadVal == 10'd1, "R1 interval reset", rereadVal, 1);
    check(curReadAddr == BASE_LO, "R1 read address", curReadAddr, BASE_LO);
    check(ringMask == 32'h0000_1FFF, "R6 mask readback", ringMask, 32'h1FFF);

    writeReread(10'd0, 10'd1);
    writeReread(10'd700, 10'd700);
    writeReread(10'd0, 10'd1);
    writeReread(10'(REREAD), 10'(REREAD));

    // R10 enable low: nothing starts
    seen = 0;
    repeat (20) begin
      @(negedge clk);
      if (memReqValid) seen = 1;
    end
    check(!seen, "R10 no fetch while disabled", seen, 0);

    // full lap of the ring
    cfgEnable = 1'b1;
    while (wbCount < RING) @(negedge clk);
    // R6 wrap to base
    waitRead(BASE_LO);
    check(expIdx == 0, "R6 wrapped to base", 64'(expIdx), 0);

    // R7 re-read period on a non-owned slot
    for (int r = 0; r < 2; r++) begin
      gap = 0;
      do begin @(negedge clk); gap++; end
      while (!(memReqValid && !memReqWrite && memReqAddr[31:0] == BASE_LO));
      check(gap == PERIOD, "R7 re-read period", 64'(gap), 64'(PERIOD));
    end

    // R8 poll immediate in the first wait cycle
    waitRead(BASE_LO + 32'd12);
    repeat (3) @(negedge clk);
    pollNow = 1'b1;
    @(negedge clk);
    pollNow = 1'b0;
    check(memReqValid && !memReqWrite && memReqAddr[31:0] == BASE_LO, "R8 poll re-read",
          memReqAddr[31:0], BASE_LO);

    // owned again: block resumes at the same slot
    for (int i = 0; i < RING; i++) validArr[i] = 1'b1;
    target = wbCount + 6;
    while (wbCount < target) @(negedge clk);

    // R9 clear
    @(negedge clk);
    cfgClear = 1'b1;
    @(negedge clk);
    expIdx = 0;
    for (int i = 0; i < RING; i++) validArr[i] = 1'b1;
    repeat (2) @(negedge clk);
    check(memReqValid == 1'b0, "R9 no request in clear", memReqValid, 0);
    check(descValid == 1'b0, "R9 no offer in clear", descValid, 0);
    check(curReadAddr == BASE_LO, "R9 pointer at base", curReadAddr, BASE_LO);
    repeat (3) @(negedge clk);
    cfgClear = 1'b0;
    do @(negedge clk); while (!(memReqValid && !memReqWrite));
    check(memReqAddr[31:0] == BASE_LO, "R9 restart at base", memReqAddr[31:0], BASE_LO);
    target = wbCount + 12;
    while (wbCount < target) @(negedge clk);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wbCount, RING);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule